// File: doc/BRIEF.md
# PRBS31 Lane Pattern Source and Checker

This block tests one serial lane with a 32-bit-per-clock stream of the PRBS31 pattern. The transmit half starts from a fixed seed and produces one new word on every clock where it is not held. Software-facing logic can freeze it with a pause input. A rising edge on a request input corrupts exactly one bit of one outgoing word, so an error path can be proven end to end.

The receive half takes the lane's recovered words and first trains itself on them. While out of lock it predicts each next word from the word just received. Once enough consecutive predictions hit, it declares lock and from then on predicts only from its own state. Mismatching words are then flagged. When errors pile up inside a short sliding window, the checker gives up lock and retrains.

Both halves keep saturating word and error counts. Receive comparison stops whenever the lane says its data is not valid or when a receive pause is applied.

Top module: `prbs_lane_tester`

## Requirements
- R1: Each transmitted word carries the next 32 bits of the PRBS31 stream. Bit 0 is the earliest bit in time, and every stream bit equals the XOR of the bits 31 and 28 positions earlier.
- R2: After reset, the transmitted words are 0x55555555, 0x5FFFFFFF, 0x2A000000, 0x17A00000 and 0x0AAA0000, in that order.
- R3: While tx_pause is high, tx_data holds its value and tx_word_cnt does not change.
- R4: A low-to-high change of inj_req inverts bit 0 of the next unpaused transmitted word only, and adds one to tx_err_cnt. Holding inj_req high causes no further errors.
- R5: tx_word_cnt adds one for every clock with tx_pause low.
- R6: A receive cycle is active when rx_valid is high and rx_pause is low. When out of lock, the first active word seeds the checker. rx_lock rises in the cycle after the 31st consecutive active word that matches the prediction.
- R7: While a cycle is not active, the checker neither compares nor advances. The receive counts and rx_lock are unchanged, and comparison resumes in step once the cycles become active again.
- R8: While locked, an active word that differs from the prediction raises rx_err and adds one to rx_err_cnt. Every other active word, including every word before lock, adds one to rx_word_cnt.
- R9: When a flagged word is the 4th flagged word among the last 32 compared words, rx_lock falls in the next cycle. The checker reseeds from that word and relocks after 31 more matching words.
- R10: Fewer than 4 flagged words among the last 32 compared words leave rx_lock high. Errors older than that window are forgotten.
- R11: Every count saturates at all ones instead of wrapping.
- R12: A synchronous active-high rst clears all counts and rx_lock and reloads the seed onto tx_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_pause | input | 1 | Hold the transmit pattern |
| inj_req | input | 1 | Error injection request, rising edge acts |
| tx_data | output | 32 | Transmitted word |
| rx_data | input | 32 | Received word |
| rx_valid | input | 1 | Received word is valid |
| rx_pause | input | 1 | Hold the receive checker |
| rx_lock | output | 1 | Checker locked to the stream |
| rx_err | output | 1 | Current received word is in error (locked, active) |
| tx_word_cnt | output | CNT_W | Transmitted words |
| tx_err_cnt | output | CNT_W | Injected errors |
| rx_word_cnt | output | CNT_W | Good received words |
| rx_err_cnt | output | CNT_W | Errored received words |

## Verification
A wrong transmit state shows at once: the first word that differs from the independent bit-serial stream model fails the scoreboard in that same cycle. A wrong receive prediction shows within one active word after lock, as a jump in rx_err_cnt on a clean loopback. A wrong lock threshold, window or reseed rule moves the cycle in which rx_lock rises or falls. The bench pins those edges to the exact cycle on both sides.

// File: rtl/prbs_lane_tester.sv
module prbs_lane_tester #(
  parameter logic [31:0] SEED      = 32'h5555_5555,
  parameter int          LOCK_RUN  = 31,
  parameter int          LOSS_ERRS = 4,
  parameter int          LOSS_WIN  = 32,
  parameter int          CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_pause,
  input  logic             inj_req,
  output logic [31:0]      tx_data,
  input  logic [31:0]      rx_data,
  input  logic             rx_valid,
  input  logic             rx_pause,
  output logic             rx_lock,
  output logic             rx_err,
  output logic [CNT_W-1:0] tx_word_cnt,
  output logic [CNT_W-1:0] tx_err_cnt,
  output logic [CNT_W-1:0] rx_word_cnt,
  output logic [CNT_W-1:0] rx_err_cnt
);

  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [31:0] prbs_step(input logic [31:0] w);
    logic [63:0] e;
    e = {32'b0, w};
    for (int j = 0; j < 32; j++) e[32+j] = e[1+j] ^ e[4+j];
    return e[63:32];
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c, input logic en);
    return (en && c != CNT_MAX) ? c + CNT_W'(1) : c;
  endfunction

  logic [31:0] gen_q;
  logic        req_q, pend_q;
  wire         inj_edge = inj_req & ~req_q;

  assign tx_data = gen_q ^ {31'b0, pend_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q       <= SEED;
      req_q       <= 1'b0;
      pend_q      <= 1'b0;
      tx_word_cnt <= '0;
      tx_err_cnt  <= '0;
    end else begin
      req_q       <= inj_req;
      pend_q      <= (pend_q & tx_pause) | inj_edge;
      if (!tx_pause) gen_q <= prbs_step(gen_q);
      tx_word_cnt <= bump(tx_word_cnt, !tx_pause);
      tx_err_cnt  <= bump(tx_err_cnt, pend_q & !tx_pause);
    end
  end

  logic [31:0]         pred_q;
  logic [RUN_W-1:0]    run_q;
  logic [LOSS_WIN-1:0] hist_q;

  wire                rx_act  = rx_valid & ~rx_pause;
  wire                miss    = rx_data != pred_q;
  wire [LOSS_WIN-1:0] hist_nx = {hist_q[LOSS_WIN-2:0], miss};
  assign rx_err = rx_act & rx_lock & miss;
  wire                drop    = rx_err && ($countones(hist_nx) >= LOSS_ERRS);

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_q      <= '0;
      run_q       <= '0;
      hist_q      <= '0;
      rx_lock     <= 1'b0;
      rx_word_cnt <= '0;
      rx_err_cnt  <= '0;
    end else begin
      if (rx_act) begin
        if (!rx_lock) begin
          pred_q <= prbs_step(rx_data);
          if (miss) run_q <= '0;
          else if (run_q == RUN_W'(LOCK_RUN - 1)) begin
            rx_lock <= 1'b1;
            run_q   <= '0;
          end else run_q <= run_q + RUN_W'(1);
        end else if (drop) begin
          rx_lock <= 1'b0;
          hist_q  <= '0;
          run_q   <= '0;
          pred_q  <= prbs_step(rx_data);
        end else begin
          hist_q <= hist_nx;
          pred_q <= prbs_step(pred_q);
        end
      end
      rx_word_cnt <= bump(rx_word_cnt, rx_act & ~rx_err);
      rx_err_cnt  <= bump(rx_err_cnt, rx_err);
    end
  end

  // R3
  tx_pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_pause |=> $stable(tx_word_cnt));
  // R4
  tx_err_unpaused_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_err_cnt != $past(tx_err_cnt)) |-> !$past(tx_pause));
  // R7
  rx_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && !rx_pause) |=> ($stable(rx_word_cnt) && $stable(rx_err_cnt) && $stable(rx_lock)));
  // R6
  lock_rise_active_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_lock) |-> $past(rx_valid && !rx_pause));
  // R10
  window_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rx_lock |-> ($countones(hist_q) < LOSS_ERRS));
  // R11
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tx_word_cnt >= $past(tx_word_cnt) && rx_word_cnt >= $past(rx_word_cnt)));

endmodule

// File: tb/tb_prbs_lane_tester.sv
`timescale 1ns/1ps
module tb_prbs_lane_tester;
  localparam logic [31:0] SEED = 32'h5555_5555;

  logic clk = 0, rst = 1, tx_pause = 0, inj_req = 0, rx_valid = 0, rx_pause = 0, corrupt = 0;
  logic [31:0] tx_data, rx_data, tx_word_cnt, tx_err_cnt, rx_word_cnt, rx_err_cnt;
  logic rx_lock, rx_err;
  logic [31:0] tx_data_s;
  logic [3:0] txw_s, txe_s, rxw_s, rxe_s;
  logic lock_s, err_s;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign rx_data = corrupt ? (tx_data ^ 32'h1) : tx_data;

  prbs_lane_tester dut (.clk(clk), .rst(rst), .tx_pause(tx_pause), .inj_req(inj_req),
    .tx_data(tx_data), .rx_data(rx_data), .rx_valid(rx_valid), .rx_pause(rx_pause),
    .rx_lock(rx_lock), .rx_err(rx_err), .tx_word_cnt(tx_word_cnt), .tx_err_cnt(tx_err_cnt),
    .rx_word_cnt(rx_word_cnt), .rx_err_cnt(rx_err_cnt));

  prbs_lane_tester #(.CNT_W(4)) dut_sat (.clk(clk), .rst(rst), .tx_pause(tx_pause),
    .inj_req(inj_req), .tx_data(tx_data_s), .rx_data(tx_data_s), .rx_valid(1'b1),
    .rx_pause(1'b0), .rx_lock(lock_s), .rx_err(err_s), .tx_word_cnt(txw_s),
    .tx_err_cnt(txe_s), .rx_word_cnt(rxw_s), .rx_err_cnt(rxe_s));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic neg;
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // bit-serial stream model and scoreboard
  bit bq[$];
  logic [31:0] exp_q[$];
  bit mpend = 0, mprev = 0;

  function automatic void bq_reset();
    bq.delete();
    for (int i = 0; i < 32; i++) bq.push_back(SEED[i]);
  endfunction

  function automatic logic [31:0] bq_word();
    logic [31:0] w;
    for (int i = 0; i < 32; i++) w[i] = bq[i];
    return w;
  endfunction

  function automatic void bq_adv();
    while (bq.size() < 64) bq.push_back(bq[bq.size()-31] ^ bq[bq.size()-28]);
    repeat (32) void'(bq.pop_front());
  endfunction

  always @(negedge clk) begin
    logic [31:0] w;
    if (rst) begin
      bq_reset();
      exp_q.delete();
      mpend = 0;
      mprev = 0;
    end else begin
      if (!tx_pause) begin
        w = bq_word();
        if (mpend) begin
          w[0] = ~w[0];
          mpend = 0;
        end
        exp_q.push_back(w);
        bq_adv();
      end
      if (inj_req && !mprev) mpend = 1;
      mprev = inj_req;
    end
  end

  always @(negedge clk) begin
    logic [31:0] e;
    #2;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(tx_data == e, "R1", "stream word", tx_data, e);  // R4 flips modelled here too
    end
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  logic [31:0] s_txw, s_txe, s_rxw, s_rxe, s_word;
  logic [31:0] lits [5];

  initial begin
    lits[0] = 32'h5555_5555; lits[1] = 32'h5FFF_FFFF; lits[2] = 32'h2A00_0000;
    lits[3] = 32'h17A0_0000; lits[4] = 32'h0AAA_0000;
    tick(3); neg;
    chk(tx_data == SEED, "R12", "reset tx_data", tx_data, SEED);
    chk(tx_word_cnt == 0 && rx_word_cnt == 0, "R12", "reset word counts", tx_word_cnt | rx_word_cnt, 0);
    chk({31'b0, rx_lock} == 0, "R12", "reset lock", {31'b0, rx_lock}, 0);

    tick(1); rst = 0; neg;
    chk(tx_data == lits[0], "R2", "word 0", tx_data, lits[0]);
    for (int k = 1; k < 5; k++) begin
      tick(1); neg;
      chk(tx_data == lits[k], "R2", "early word", tx_data, lits[k]);
    end
    chk(tx_word_cnt == 4, "R5", "tx words after 4 cycles", tx_word_cnt, 4);

    // checker joins mid-stream
    tick(41); rx_valid = 1;
    tick(31); neg;
    chk({31'b0, rx_lock} == 0, "R6", "no lock after 30 matches", {31'b0, rx_lock}, 0);
    tick(1); neg;
    chk({31'b0, rx_lock} == 1, "R6", "lock after 31 matches", {31'b0, rx_lock}, 1);
    chk(rx_err_cnt == 0, "R8", "no errors before lock", rx_err_cnt, 0);
    chk(rx_word_cnt == 32, "R8", "words before lock", rx_word_cnt, 32);

    // single injection, held high
    tick(1); inj_req = 1; neg;
    s_txw = tx_word_cnt; s_txe = tx_err_cnt; s_rxw = rx_word_cnt; s_rxe = rx_err_cnt;
    tick(3); inj_req = 0;
    tick(7); neg;
    chk(tx_word_cnt - s_txw == 10, "R5", "tx words over 10", tx_word_cnt - s_txw, 10);
    chk(tx_err_cnt - s_txe == 1, "R4", "one injected error", tx_err_cnt - s_txe, 1);
    chk(rx_err_cnt - s_rxe == 1, "R8", "one detected error", rx_err_cnt - s_rxe, 1);
    chk(rx_word_cnt - s_rxw == 9, "R8", "good words", rx_word_cnt - s_rxw, 9);
    chk({31'b0, rx_lock} == 1, "R10", "lock held after 1 error", {31'b0, rx_lock}, 1);

    // both halves paused
    tick(1); tx_pause = 1; rx_pause = 1; neg;
    s_txw = tx_word_cnt; s_rxw = rx_word_cnt; s_rxe = rx_err_cnt; s_word = tx_data;
    tick(6); neg;
    chk(tx_word_cnt == s_txw, "R3", "tx count held", tx_word_cnt, s_txw);
    chk(tx_data == s_word, "R3", "tx word held", tx_data, s_word);
    chk(rx_word_cnt == s_rxw && rx_err_cnt == s_rxe, "R7", "rx counts held on pause", rx_word_cnt, s_rxw);
    chk({31'b0, rx_lock} == 1, "R7", "lock held on pause", {31'b0, rx_lock}, 1);
    tick(1); tx_pause = 0; rx_pause = 0; neg;
    s_rxw = rx_word_cnt; s_rxe = rx_err_cnt;
    tick(10); neg;
    chk(rx_err_cnt == s_rxe, "R7", "in step after pause", rx_err_cnt, s_rxe);
    chk(rx_word_cnt - s_rxw == 10, "R7", "words after pause", rx_word_cnt - s_rxw, 10);

    // invalid receive data with garbage on the wire
    tick(1); tx_pause = 1; rx_valid = 0; corrupt = 1; neg;
    s_rxw = rx_word_cnt; s_rxe = rx_err_cnt;
    tick(6); neg;
    chk(rx_word_cnt == s_rxw && rx_err_cnt == s_rxe, "R7", "invalid data ignored", rx_err_cnt, s_rxe);
    chk({31'b0, rx_lock} == 1, "R7", "lock held while invalid", {31'b0, rx_lock}, 1);
    tick(1); tx_pause = 0; rx_valid = 1; corrupt = 0; neg;
    s_rxe = rx_err_cnt;
    tick(10); neg;
    chk(rx_err_cnt == s_rxe, "R7", "in step after invalid", rx_err_cnt, s_rxe);

    // three errors then recovery window
    tick(40); corrupt = 1; neg;
    s_rxe = rx_err_cnt;
    tick(3); corrupt = 0; neg;
    chk(rx_err_cnt - s_rxe == 3, "R8", "three errors", rx_err_cnt - s_rxe, 3);
    chk({31'b0, rx_lock} == 1, "R10", "lock held after 3", {31'b0, rx_lock}, 1);
    tick(40); corrupt = 1; neg;
    s_rxe = rx_err_cnt;
    tick(3); neg;
    chk({31'b0, rx_lock} == 1, "R10", "old errors forgotten", {31'b0, rx_lock}, 1);
    tick(1); corrupt = 0; neg;
    chk({31'b0, rx_lock} == 0, "R9", "lock lost on 4th", {31'b0, rx_lock}, 0);
    chk(rx_err_cnt - s_rxe == 4, "R9", "four errors", rx_err_cnt - s_rxe, 4);
    tick(30); neg;
    chk({31'b0, rx_lock} == 0, "R9", "not yet relocked", {31'b0, rx_lock}, 0);
    tick(1); neg;
    chk({31'b0, rx_lock} == 1, "R9", "relocked", {31'b0, rx_lock}, 1);

    chk({28'b0, txw_s} == 15, "R11", "tx count saturates", {28'b0, txw_s}, 15);
    chk({28'b0, rxw_s} == 15, "R11", "rx count saturates", {28'b0, rxw_s}, 15);

    tick(1); rst = 1; tick(1); neg;
    chk(tx_data == SEED, "R12", "seed reloaded", tx_data, SEED);
    chk(tx_word_cnt == 0 && tx_err_cnt == 0, "R12", "tx counts cleared", tx_word_cnt | tx_err_cnt, 0);
    chk(rx_word_cnt == 0 && rx_err_cnt == 0, "R12", "rx counts cleared", rx_word_cnt | rx_err_cnt, 0);
    chk({31'b0, rx_lock} == 0, "R12", "lock cleared", {31'b0, rx_lock}, 0);
    finish_run();
  end
endmodule